// File: doc/BRIEF.md
# Controller Rendezvous Barrier

This block keeps up to four array controllers in step when they are joined into one united configuration. Instructions for the group are fetched once and broadcast to every joined controller. After that, each controller runs on its own. It only stops to meet the others at four kinds of points: a new instruction-block fetch, a data routing step, a conditional program transfer and a change of configuration. At one of these points, a controller pulses its arrive line and gives the event type on its own type lane. It then holds, as shown by its wait flag, until the barrier sends a common release pulse.

A participation mask holds one bit per controller and decides who takes part in the rendezvous. Controllers whose bit is clear are never held. Their arrive pulses have no effect, so their arrays keep their memory cycles. If a controller arrives with an event type that differs from the round's type, an error pulse is raised. The release pulse also carries the event type of the round that completed.

Top module: `sync_barrier`

## Requirements
- R1: After reset, release_o, mismatch_o and every wait_o bit are 0.
- R2: An arrive pulse from a controller whose mask bit is 1 sets its wait_o bit from the next cycle on. The bit stays set until the round is released.
- R3: In the cycle after the edge at which the last masked controller arrives, release_o is 1 for one cycle and all wait_o bits read 0.
- R4: An arrive pulse from a controller whose mask bit is 0 is ignored. It sets no wait bit, and it neither completes a round nor holds one back.
- R5: A further arrive pulse from a controller that is already waiting has no effect on the wait flags or on the release timing.
- R6: release_evt_o gives the round's event type in the release cycle. The encoding per 2-bit lane is 0 block fetch, 1 data routing, 2 conditional transfer, 3 configuration change. Controller i uses bits [2i+1:2i] of evt_type_i.
- R7: The round's type is the type of its first arrival. Among simultaneous first arrivals, the lowest controller index wins. mismatch_o pulses for one cycle after any edge at which a masked arrival carries a different type.
- R8: With an all-zero mask, no release is ever produced.
- R9: Clearing a mask bit while a round is open drops that controller from the round. If all remaining masked controllers have arrived, release follows in the next cycle.
- R10: When all masked controllers arrive at the same edge, the release follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| part_mask_i | input | 4 | Participation mask, one bit per controller |
| arrive_i | input | 4 | Per-controller arrive strobe |
| evt_type_i | input | 8 | Per-controller event type, 2 bits per lane |
| wait_o | output | 4 | Controller is held at the barrier |
| release_o | output | 1 | One-cycle common release |
| release_evt_o | output | 2 | Event type of the released round |
| mismatch_o | output | 1 | One-cycle event-type mismatch pulse |

## Verification
Staggered arrivals under a full mask show that release waits for the last controller. All-at-once arrivals show the single-cycle path, and the two cases are told apart only by the release cycle. Sparse masks with stray arrivals from excluded lanes separate "ignored" from "counted". Repeated arrivals separate idempotent flags from counting. Mixed types, both staggered and simultaneous, show which controller's type sets the round's reference. Dropping a mask bit mid-round, and an all-zero mask, cover completion by removal and the case with no participants.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned EVT_W = 2;

  typedef enum logic [EVT_W-1:0] {
    EVT_BLOCK_FETCH = 2'd0,
    EVT_ROUTE       = 2'd1,
    EVT_COND_XFER   = 2'd2,
    EVT_CFG_CHANGE  = 2'd3
  } sync_evt_e;
endpackage

// File: rtl/sb_lane.sv
module sb_lane (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic part_i,
  input  logic arrive_i,
  input  logic clear_i,
  output logic take_o,
  output logic wait_o
);
  logic arrived_q;

  assign take_o = arrive_i & part_i & ~arrived_q;
  assign wait_o = arrived_q & part_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      arrived_q <= 1'b0;
    else if (clear_i) arrived_q <= 1'b0;
    else              arrived_q <= wait_o | take_o;
  end

  p_excluded_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !part_i |=> !arrived_q);
  p_set_needs_arrive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arrived_q) |-> $past(arrive_i && part_i));
endmodule

// File: rtl/sb_ref.sv
module sb_ref #(
  parameter int unsigned N_CTRL = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [N_CTRL-1:0]                  take_i,
  input  logic [N_CTRL*sb_pkg::EVT_W-1:0]    evt_i,
  input  logic                               any_wait_i,
  input  logic                               complete_i,
  output sb_pkg::sync_evt_e                  cur_ref_o,
  output logic                               mismatch_o
);
  import sb_pkg::*;

  logic      ref_valid_q;
  sync_evt_e ref_q;
  sync_evt_e first_evt;
  logic      mm_d, mismatch_q;

  // lowest arriving index sets the reference for a fresh round
  always_comb begin
    first_evt = EVT_BLOCK_FETCH;
    for (int i = N_CTRL - 1; i >= 0; i--) begin
      if (take_i[i]) first_evt = sync_evt_e'(evt_i[i*EVT_W +: EVT_W]);
    end
  end

  assign cur_ref_o = ref_valid_q ? ref_q : first_evt;

  always_comb begin
    mm_d = 1'b0;
    for (int i = 0; i < N_CTRL; i++) begin
      if (take_i[i] && (evt_i[i*EVT_W +: EVT_W] != cur_ref_o)) mm_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_valid_q <= 1'b0;
      ref_q       <= EVT_BLOCK_FETCH;
      mismatch_q  <= 1'b0;
    end else begin
      mismatch_q  <= mm_d;
      ref_valid_q <= ~complete_i & (any_wait_i | (|take_i));
      if (|take_i) ref_q <= cur_ref_o;
    end
  end

  assign mismatch_o = mismatch_q;

  p_mismatch_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_q |-> $past(|take_i));
  p_ref_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_q && $past(ref_valid_q)) |-> $stable(ref_q));
endmodule

// File: rtl/sb_release.sv
module sb_release (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              complete_i,
  input  sb_pkg::sync_evt_e evt_i,
  output logic              release_o,
  output sb_pkg::sync_evt_e evt_o
);
  import sb_pkg::*;

  logic      rel_q;
  sync_evt_e evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q <= 1'b0;
      evt_q <= EVT_BLOCK_FETCH;
    end else begin
      rel_q <= complete_i;
      if (complete_i) evt_q <= evt_i;
    end
  end

  assign release_o = rel_q;
  assign evt_o     = evt_q;

  p_evt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rel_q |-> $stable(evt_q));
endmodule

// File: rtl/sync_barrier.sv
module sync_barrier #(
  parameter int unsigned N_CTRL = 4,
  localparam int unsigned TW    = N_CTRL * sb_pkg::EVT_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_CTRL-1:0]        part_mask_i,
  input  logic [N_CTRL-1:0]        arrive_i,
  input  logic [TW-1:0]            evt_type_i,
  output logic [N_CTRL-1:0]        wait_o,
  output logic                     release_o,
  output logic [sb_pkg::EVT_W-1:0] release_evt_o,
  output logic                     mismatch_o
);
  import sb_pkg::*;

  logic [N_CTRL-1:0] take, waiting;
  logic              complete;
  sync_evt_e         cur_ref, rel_evt;

  for (genvar g = 0; g < N_CTRL; g++) begin : g_lane
    sb_lane i_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .part_i  (part_mask_i[g]),
      .arrive_i(arrive_i[g]),
      .clear_i (complete),
      .take_o  (take[g]),
      .wait_o  (waiting[g])
    );
  end

  // every masked lane either already waiting or arriving now
  assign complete = (|part_mask_i) & (&(waiting | take | ~part_mask_i));

  sb_ref #(.N_CTRL(N_CTRL)) i_ref (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .evt_i     (evt_type_i),
    .any_wait_i(|waiting),
    .complete_i(complete),
    .cur_ref_o (cur_ref),
    .mismatch_o(mismatch_o)
  );

  sb_release i_rel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .complete_i(complete),
    .evt_i     (cur_ref),
    .release_o (release_o),
    .evt_o     (rel_evt)
  );

  assign wait_o        = waiting;
  assign release_evt_o = rel_evt;

  p_release_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |-> (wait_o == '0));
  p_empty_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |-> $past(|part_mask_i));
  p_wait_masked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o & ~part_mask_i) == '0);
endmodule

// File: tb/test_sync_barrier.sv
module test_sync_barrier;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] part_mask_i = '0;
  logic [N-1:0] arrive_i = '0;
  logic [2*N-1:0] evt_type_i = '0;
  logic [N-1:0] wait_o;
  logic         release_o;
  logic [1:0]   release_evt_o;
  logic         mismatch_o;

  sync_barrier #(.N_CTRL(N)) i_sync_barrier (
    .clk_i(clk), .rst_ni(rst_ni), .part_mask_i(part_mask_i), .arrive_i(arrive_i),
    .evt_type_i(evt_type_i), .wait_o(wait_o), .release_o(release_o),
    .release_evt_o(release_evt_o), .mismatch_o(mismatch_o)
  );

  always #2 clk = ~clk;

  typedef struct { int cyc; logic [1:0] evt; } rel_item_t;
  rel_item_t rel_q[$];
  int        mm_q[$];

  int checks = 0, errors = 0, cyc = 0;
  bit running = 0, done = 0;
  string req = "R1";
  logic [N-1:0] m_arr = '0, exp_wait = '0;
  logic         m_ref_v = 0;
  logic [1:0]   m_ref = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", r, what, act, exp, cyc);
    end
  endtask

  // driver: applies one cycle of stimulus at negedge and predicts results
  task automatic drive(logic [N-1:0] mask, logic [N-1:0] arr, logic [2*N-1:0] ty);
    logic [N-1:0] tk;
    logic mm;
    @(negedge clk);
    part_mask_i = mask; arrive_i = arr; evt_type_i = ty;
    m_arr = m_arr & mask;
    tk = arr & mask & ~m_arr;
    if (!m_ref_v) begin
      for (int i = N - 1; i >= 0; i--) if (tk[i]) m_ref = ty[2*i +: 2];
    end
    mm = 0;
    for (int i = 0; i < N; i++) if (tk[i] && ty[2*i +: 2] != m_ref) mm = 1;
    if (mm) mm_q.push_back(cyc + 1);
    m_arr = m_arr | tk;
    if (mask != 0 && (m_arr | ~mask) == '1) begin
      rel_q.push_back('{cyc + 1, m_ref});
      m_arr = '0; m_ref_v = 0;
    end else begin
      m_ref_v = (m_arr != 0);
    end
    exp_wait = m_arr;
  endtask

  task automatic idle(int n, logic [N-1:0] mask);
    for (int k = 0; k < n; k++) drive(mask, '0, '0);
  endtask

  // monitor: compares outputs just after each edge against the scoreboard
  initial begin
    forever begin
      @(posedge clk); #1;
      if (running) begin
        logic er, em;
        logic [1:0] ee;
        er = 0; em = 0; ee = 0;
        if (rel_q.size() > 0 && rel_q[0].cyc == cyc) begin
          er = 1; ee = rel_q[0].evt; void'(rel_q.pop_front());
        end
        if (mm_q.size() > 0 && mm_q[0] == cyc) begin
          em = 1; void'(mm_q.pop_front());
        end
        chk(req, "wait_o", wait_o, exp_wait);
        chk(req, "release_o", release_o, er);
        if (er) chk(req, "release_evt_o", release_evt_o, ee);
        chk(req, "mismatch_o", mismatch_o, em);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset release_o", release_o, 0);
    chk("R1", "reset wait_o", wait_o, 0);
    chk("R1", "reset mismatch_o", mismatch_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    running = 1;
    idle(2, 4'b1111);

    req = "R2/R3/R6 staggered";
    drive(4'b1111, 4'b0001, 8'b01_01_01_01);
    drive(4'b1111, 4'b0000, '0);
    drive(4'b1111, 4'b0100, 8'b01_01_01_01);
    drive(4'b1111, 4'b1010, 8'b01_01_01_01);
    idle(3, 4'b1111);

    req = "R10 simultaneous";
    drive(4'b1111, 4'b1111, 8'b11_11_11_11);
    idle(2, 4'b1111);
    drive(4'b1111, 4'b1111, 8'b10_10_10_10);
    drive(4'b1111, 4'b1111, 8'b00_00_00_00);
    idle(2, 4'b1111);

    req = "R4 excluded lanes";
    drive(4'b0101, 4'b1010, 8'b11_11_11_11);
    drive(4'b0101, 4'b0001, 8'b10_10_10_10);
    drive(4'b0101, 4'b1010, 8'b10_10_10_10);
    drive(4'b0101, 4'b0100, 8'b10_10_10_10);
    idle(2, 4'b0101);

    req = "R5 repeated arrive";
    drive(4'b0011, 4'b0001, 8'b00_00_00_00);
    drive(4'b0011, 4'b0001, 8'b00_00_00_00);
    drive(4'b0011, 4'b0001, 8'b00_00_00_00);
    drive(4'b0011, 4'b0010, 8'b00_00_00_00);
    idle(2, 4'b0011);

    req = "R7 staggered mismatch";
    drive(4'b0011, 4'b0001, 8'b00_00_00_00);
    drive(4'b0011, 4'b0010, 8'b00_00_10_00);
    idle(2, 4'b0011);
    req = "R7 simultaneous mismatch";
    drive(4'b0011, 4'b0011, 8'b00_00_01_10);
    idle(2, 4'b0011);

    req = "R8 empty mask";
    drive(4'b0000, 4'b1111, 8'b01_01_01_01);
    drive(4'b0000, 4'b1111, 8'b01_01_01_01);
    idle(3, 4'b0000);

    req = "R9 mask drop";
    drive(4'b1111, 4'b0111, 8'b11_11_11_11);
    drive(4'b1111, 4'b0000, '0);
    drive(4'b0111, 4'b0000, '0);
    idle(3, 4'b0111);

    running = 0;
    chk("R3", "scoreboard drained", rel_q.size() + mm_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule